// File: doc/BRIEF.md
# Ready-Line Handshake Controller (Peripheral Side)

This block runs the peripheral end of a two-wire, active-low ready handshake that brackets every transaction on a serial link between a host controller and a network processor. It watches the controller's ready line, which arrives asynchronously, and drives the peripheral's own ready line. A transaction may be opened by either party. The local side opens one when its transfer engine has something to send. The remote side opens one by pulling its ready line low.

Whichever side opens it, the block first asks the local transfer engine to arm its receive path. It waits for the engine's acknowledge before pulling the peripheral ready line low. It then grants data movement in both directions for as long as both lines are low. When the controller lets its line go high, the block releases the peripheral line, emits a one-cycle completion strobe and returns to idle. A status output tells the engine whether the current transaction was opened by the remote side.

Top module: `rdy_handshake`

## Requirements
- R1: While reset is asserted and after its release with no activity, `srdyN` is 1 and `armRx`, `xferEn`, `xferDone` and `remoteInit` are 0.
- R2: `mrdyN` passes through a synchroniser of `SYNC_STAGES` flops, default 2. With no local request, a falling `mrdyN` raises `armRx` on the (`SYNC_STAGES`+1)th rising clock edge after the change, and not before.
- R3: A local `sendReq` sampled high in idle raises `armRx` on the next rising edge. `srdyN` stays 1 for any number of cycles while `rxArmAck` is 0. `srdyN` falls on the first rising edge at which `armRx` and `rxArmAck` are both 1.
- R4: Every transaction, local or remote, asserts `armRx` before `srdyN` falls. `armRx` drops on the same edge at which `srdyN` falls.
- R5: `xferEn` is 1 only while `srdyN` is 0 and the synchronised controller line is low. A locally opened transaction waits with `srdyN` = 0 and `xferEn` = 0 until the controller asserts its line.
- R6: During a transfer, a rise of `mrdyN` drops `xferEn` on the `SYNC_STAGES`th edge after the change. On the next edge, `srdyN` returns to 1 and `xferDone` is 1 for exactly one cycle.
- R7: `remoteInit` is 1 when the transaction was opened by the controller with `sendReq` low. It is 0 when `sendReq` was high at the start, including the case where both sides ask at once. The value holds until the next transaction starts.
- R8: `sendReq` is sampled only in idle. A pulse of it during an active transfer does not start a further transaction after completion.
- R9: After completion the block accepts a new transaction of either origin, back to back, with any acknowledge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mrdyN | input | 1 | Controller ready line, active low, asynchronous |
| sendReq | input | 1 | Local transfer engine has data to send |
| rxArmAck | input | 1 | Transfer engine confirms its receive path is armed |
| armRx | output | 1 | Request to arm the receive path |
| srdyN | output | 1 | Peripheral ready line, active low |
| xferEn | output | 1 | Both lines asserted; data may move both ways |
| remoteInit | output | 1 | Current or last transaction was opened by the controller |
| xferDone | output | 1 | One-cycle strobe at transaction end |

## Verification
The assertions assume that `rxArmAck` is raised only in answer to `armRx`. They also assume that the controller releases its line only after both lines have been low, so a rise of the synchronised line is seen only during a transfer. The stimulus follows both rules. It raises the acknowledge only after `armRx` has been observed and clears it once `srdyN` has fallen. It holds `mrdyN` low until `xferEn` has been seen before releasing it. All inputs change on the falling clock edge, so the synchroniser never sees a change near its sampling edge.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_READY  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_DONE   = 3'd4
  } hsState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic srdyAssert;    // pull peripheral ready low
    logic srdyRelease;   // let peripheral ready go high
    logic captureOrigin; // latch who opened the transaction
    logic originRemote;  // value to latch
  } hsCtrl_t;

endpackage

// File: rtl/rdy_hs_path.sv
module rdy_hs_path
  import rdy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mrdyN,
  input  hsCtrl_t ctrl,
  output logic    mrdyLow,
  output logic    mrdyRise,
  output logic    srdyN,
  output logic    remoteInit
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stageQ;
  logic          prevQ;
  logic          srdyQ;
  logic          originQ;

  // Synchroniser chain, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '1;
      prevQ  <= 1'b1;
    end else begin
      stageQ <= {stageQ[LAST-1:0], mrdyN};
      prevQ  <= stageQ[LAST];
    end
  end

  assign mrdyLow  = ~stageQ[LAST];
  assign mrdyRise = stageQ[LAST] & ~prevQ;

  // Peripheral ready register, moved only by control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srdyQ <= 1'b1;
    end else if (ctrl.srdyAssert) begin
      srdyQ <= 1'b0;
    end else if (ctrl.srdyRelease) begin
      srdyQ <= 1'b1;
    end
  end

  // Origin of the transaction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      originQ <= 1'b0;
    end else if (ctrl.captureOrigin) begin
      originQ <= ctrl.originRemote;
    end
  end

  assign srdyN      = srdyQ;
  assign remoteInit = originQ;

endmodule

// File: rtl/rdy_hs_ctrl.sv
module rdy_hs_ctrl
  import rdy_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sendReq,
  input  logic    rxArmAck,
  input  logic    mrdyLow,
  input  logic    mrdyRise,
  output hsCtrl_t ctrl,
  output logic    armRx,
  output logic    xferEn,
  output logic    xferDone
);

  hsState_t stateQ;
  hsState_t stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (sendReq || mrdyLow) begin
          stateD             = ST_ARM;
          ctrl.captureOrigin = 1'b1;
          ctrl.originRemote  = ~sendReq; // local request wins a tie
        end
      end
      ST_ARM: begin
        if (rxArmAck) begin
          stateD          = ST_READY;
          ctrl.srdyAssert = 1'b1;
        end
      end
      ST_READY: begin
        if (mrdyLow) begin
          stateD = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (mrdyRise) begin
          stateD           = ST_DONE;
          ctrl.srdyRelease = 1'b1;
        end
      end
      ST_DONE: begin
        stateD = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  assign armRx    = (stateQ == ST_ARM);
  assign xferEn   = (stateQ == ST_ACTIVE) && mrdyLow;
  assign xferDone = (stateQ == ST_DONE);

endmodule

// File: rtl/rdy_handshake.sv
module rdy_handshake
  import rdy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic mrdyN,
  input  logic sendReq,
  input  logic rxArmAck,
  output logic armRx,
  output logic srdyN,
  output logic xferEn,
  output logic remoteInit,
  output logic xferDone
);

  hsCtrl_t ctrl;
  logic    mrdyLow;
  logic    mrdyRise;

  rdy_hs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sendReq  (sendReq),
    .rxArmAck (rxArmAck),
    .mrdyLow  (mrdyLow),
    .mrdyRise (mrdyRise),
    .ctrl     (ctrl),
    .armRx    (armRx),
    .xferEn   (xferEn),
    .xferDone (xferDone)
  );

  rdy_hs_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .mrdyN      (mrdyN),
    .ctrl       (ctrl),
    .mrdyLow    (mrdyLow),
    .mrdyRise   (mrdyRise),
    .srdyN      (srdyN),
    .remoteInit (remoteInit)
  );

endmodule

// File: rtl/rdy_handshake_chk.sv
module rdy_handshake_chk (
  input logic clk,
  input logic rstN,
  input logic rxArmAck,
  input logic armRx,
  input logic srdyN,
  input logic xferEn,
  input logic remoteInit,
  input logic xferDone
);

  // R3: ready line may only fall after an armed acknowledge
  a_r3_srdy_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srdyN) |-> $past(armRx && rxArmAck));

  // R4: arm request is withdrawn once the ready line is low
  a_r4_arm_off_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    !srdyN |-> !armRx);

  // R5: transfer grant needs the local ready line low
  a_r5_xfer_needs_srdy: assert property (@(posedge clk) disable iff (!rstN)
    xferEn |-> !srdyN);

  // R6: completion strobe is a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R6: completion coincides with ready released and no grant
  a_r6_done_released: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (srdyN && !xferEn));

  // R6: ready line rises only as the completion strobe appears
  a_r6_rise_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srdyN) |-> xferDone);

  // R7: origin flag is steady while the ready line stays low
  a_r7_origin_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!srdyN && $past(!srdyN)) |-> $stable(remoteInit));

endmodule

bind rdy_handshake rdy_handshake_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxArmAck   (rxArmAck),
  .armRx      (armRx),
  .srdyN      (srdyN),
  .xferEn     (xferEn),
  .remoteInit (remoteInit),
  .xferDone   (xferDone)
);

// File: tb/sim_rdy_handshake.sv
`timescale 1ns/1ps
module sim_rdy_handshake;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mrdyN = 1'b1;
  logic sendReq = 1'b0;
  logic rxArmAck = 1'b0;
  logic armRx, srdyN, xferEn, remoteInit, xferDone;

  int testCount = 0;
  int failCount = 0;
  bit expQ[$];

  always #4 clk = ~clk; // 125 MHz

  rdy_handshake #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .mrdyN(mrdyN), .sendReq(sendReq),
    .rxArmAck(rxArmAck), .armRx(armRx), .srdyN(srdyN), .xferEn(xferEn),
    .remoteInit(remoteInit), .xferDone(xferDone)
  );

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    check("R9 queue drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  // Monitor: pop expected origin at each completion strobe
  always @(negedge clk) begin
    if (rstN && xferDone) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected completion", 1, 0);
      end else begin
        bit e;
        e = expQ.pop_front();
        check("R7 origin at done", remoteInit, e);
        check("R6 srdy released at done", srdyN, 1);
      end
    end
  end

  // Generic transaction driver
  task automatic doTxn(input bit remote, input int ackDelay, input int hold);
    int guard;
    expQ.push_back(remote);
    if (remote) mrdyN = 1'b0; else sendReq = 1'b1;
    guard = 0;
    while (!armRx && guard < 20) begin cyc(1); guard++; end
    check("R4 arm raised", armRx, 1);
    for (int i = 0; i < ackDelay; i++) begin
      check("R3 srdy held without ack", srdyN, 1);
      cyc(1);
    end
    rxArmAck = 1'b1;
    cyc(1);
    check("R3 srdy low after ack", srdyN, 0);
    rxArmAck = 1'b0;
    sendReq  = 1'b0;
    if (!remote) begin cyc(2); mrdyN = 1'b0; end
    guard = 0;
    while (!xferEn && guard < 20) begin cyc(1); guard++; end
    check("R9 transfer granted", xferEn, 1);
    cyc(hold);
    mrdyN = 1'b1;
    guard = 0;
    while (!xferDone && guard < 20) begin cyc(1); guard++; end
    check("R9 completion seen", xferDone, 1);
    cyc(3);
  endtask

  initial begin
    #800000;
    check("watchdog", 1, 0);
    finishRun();
  end

  initial begin
    // R1 reset state
    cyc(3);
    check("R1 srdyN in reset", srdyN, 1);
    check("R1 armRx in reset", armRx, 0);
    check("R1 xferEn in reset", xferEn, 0);
    rstN = 1'b1;
    cyc(3);
    check("R1 idle srdyN", srdyN, 1);
    check("R1 idle done", xferDone, 0);
    check("R1 idle remoteInit", remoteInit, 0);

    // Local transaction with explicit timing
    expQ.push_back(1'b0);
    sendReq = 1'b1;
    cyc(1);
    check("R3 arm next edge", armRx, 1);
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      check("R3 srdy waits for ack", srdyN, 1);
      check("R3 arm held", armRx, 1);
    end
    rxArmAck = 1'b1;
    cyc(1);
    check("R3 srdy falls on ack", srdyN, 0);
    check("R4 arm drops with srdy", armRx, 0);
    rxArmAck = 1'b0;
    sendReq  = 1'b0;
    cyc(3);
    check("R5 no grant before controller", xferEn, 0);
    check("R5 srdy held low", srdyN, 0);
    mrdyN = 1'b0;
    cyc(1); check("R2 grant not yet (1)", xferEn, 0);
    cyc(1); check("R2 grant not yet (2)", xferEn, 0);
    cyc(1); check("R5 grant with both low", xferEn, 1);
    check("R7 local origin", remoteInit, 0);
    sendReq = 1'b1; // R8 stray request during transfer
    cyc(1);
    sendReq = 1'b0;
    cyc(3);
    mrdyN = 1'b1;
    cyc(1); check("R6 grant until sync", xferEn, 1);
    cyc(1); check("R6 grant drops", xferEn, 0);
    check("R6 srdy still low", srdyN, 0);
    check("R6 done not yet", xferDone, 0);
    cyc(1); check("R6 done strobe", xferDone, 1);
    cyc(1); check("R6 done one cycle", xferDone, 0);
    for (int i = 0; i < 10; i++) begin
      check("R8 stray request ignored", armRx, 0);
      cyc(1);
    end

    // Remote transaction with explicit timing
    expQ.push_back(1'b1);
    mrdyN = 1'b0;
    cyc(1); check("R2 no arm after 1 edge", armRx, 0);
    cyc(1); check("R2 no arm after 2 edges", armRx, 0);
    cyc(1); check("R2 arm after 3 edges", armRx, 1);
    check("R4 srdy high while arming", srdyN, 1);
    rxArmAck = 1'b1;
    cyc(1);
    check("R4 srdy low remote", srdyN, 0);
    check("R5 no grant on first ready cycle", xferEn, 0);
    rxArmAck = 1'b0;
    cyc(1);
    check("R5 grant remote", xferEn, 1);
    check("R7 remote origin", remoteInit, 1);
    cyc(4);
    mrdyN = 1'b1;
    cyc(3); check("R6 remote done", xferDone, 1);
    cyc(3);

    // Simultaneous request: local wins
    expQ.push_back(1'b0);
    sendReq = 1'b1;
    mrdyN   = 1'b0;
    cyc(1);
    check("R7 tie arms at once", armRx, 1);
    rxArmAck = 1'b1;
    cyc(1);
    rxArmAck = 1'b0;
    sendReq  = 1'b0;
    cyc(2);
    check("R5 tie grant", xferEn, 1);
    check("R7 tie is local", remoteInit, 0);
    mrdyN = 1'b1;
    cyc(6);

    // Back-to-back mix
    doTxn(1'b1, 0, 2);
    doTxn(1'b0, 3, 5);
    doTxn(1'b1, 7, 1);
    doTxn(1'b0, 1, 0);

    finishRun();
  end

endmodule